// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames from a byte-wide stream and stores them in memory buffers. The buffers are described by a closed ring of four-word descriptors that software builds in memory. The engine reads each descriptor over a single-ported 32-bit memory interface with byte enables. Once a descriptor is fetched, the engine is armed: the bytes of the next frame go to the buffer that descriptor names. When the frame ends, the engine writes a completion status back into the descriptor and moves on to the descriptor that the next pointer names.

Ownership works through two flags. Software sets a hold flag in a descriptor's parameter word to keep the engine away from it. The engine sets a completion flag in the status word once the frame data is in memory. An engine that finds a held descriptor does not use it. It reads the parameter word again after a programmable idle interval, and keeps doing so until the hold is lifted. A level-sensitive run input starts the engine at a base address and stops it. Frames that begin while the engine is not armed are discarded and counted.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset the memory port is idle (`mem_req` low), `drop_count` is 0 and the re-poll interval register holds 7.
- R2: Byte addresses are used throughout. A descriptor at address D is read as parameter word at D, next pointer at D+4 and buffer pointer at D+8, on three consecutive cycles. Read data returns one cycle after the request.
- R3: The parameter word holds the hold flag in bit 31, a start offset in bits 28:26 and the buffer size limit in bits 21:0. Byte i of a frame is written to byte address buffer+offset+i, with one byte per write. The byte enable for lane k (bits 8k+7:8k) selects address bits 1:0 = k. No byte is written past the stored count.
- R4: One cycle after the last byte, the engine writes the status word at D+12 with all four enables. Bit 31 is completion (1), bit 30 is start of frame (1) and bit 29 is end of frame. Bits 16:0 hold the byte count and bits 28:17 are zero.
- R5: The count in the status word is the number of bytes delivered on the stream, including the trailing 4 CRC bytes.
- R6: When a frame is longer than the size limit, only the first limit bytes are stored, the count equals the limit and the end-of-frame bit is 0.
- R7: After the status write, the next read goes to the next pointer of the completed descriptor. A ring whose last descriptor points at the first wraps around.
- R8: A descriptor with the hold flag set gets no further reads and no data writes. Its parameter word is read again every N+3 cycles, where N is the interval register.
- R9: A write through `poll_wr`/`poll_din` replaces the interval, and later re-polls use the new value.
- R10: A frame whose first byte arrives while the engine is not armed is stored nowhere and raises `drop_count` by one. This covers a stopped engine, a held descriptor, a descriptor fetch in progress, and the cycles right after a previous frame.
- R11: When `run` goes low while the engine waits for a frame or a released descriptor, all memory traffic stops. When `run` goes high again, fetching restarts at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Engine enable, level sensitive |
| ring_base | input | ADDR_W | Address of the first descriptor used after start |
| poll_wr | input | 1 | Write strobe for the re-poll interval |
| poll_din | input | POLL_W | New re-poll interval |
| rx_valid | input | 1 | A stream byte is present |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the final one of its frame |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| drop_count | output | DROP_W | Number of discarded frames, wrapping |

## Verification
The bench targets the re-poll spacing, at both the reset interval and a rewritten one. An off-by-one timer would space the parameter reads wrongly. A design that ignored the hold flag would read the next pointer early. The bench also sends a frame right behind another, while the next descriptor is still being fetched. A design that accepted that frame would scribble into a buffer it does not own. Truncation is exercised with odd start offsets and a guard byte after the limit, so an engine that stores one byte too many, or leaves the end-of-frame flag set, shows up at once. Random frames go round the three-descriptor ring several times, which exposes wrong pointer following and lane or offset arithmetic errors.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   localparam int WORD_W        = 32;
   localparam int LANES         = WORD_W / 8;
   localparam int LANE_W        = $clog2(LANES);
   // parameter word layout
   localparam int PAR_HOLD_BIT  = 31;
   localparam int PAR_OFF_LSB   = 26;
   localparam int PAR_OFF_W     = 3;
   localparam int PAR_SIZE_W    = 22;
   // status word layout
   localparam int STAT_DONE_BIT = 31;
   localparam int STAT_SOF_BIT  = 30;
   localparam int STAT_EOF_BIT  = 29;
   localparam int STAT_CNT_W    = 17;
   // descriptor word offsets in bytes
   localparam int OFS_NEXT      = 4;
   localparam int OFS_BUF       = 8;
   localparam int OFS_STAT      = 12;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RD_PAR, ST_CAP_PAR, ST_CAP_NXT, ST_CAP_BUF,
      ST_ARMED, ST_RECV, ST_WB, ST_HOLD
   } eng_state_t;
endpackage

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= load_val;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign expired = (remain == '0);

   assert_poll_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/rxd_frame_gate.sv
module rxd_frame_gate #(
   parameter int DROP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_last,
   input  logic              armed,
   output logic              sof,
   output logic [DROP_W-1:0] drop_count
);
   logic mid_frame;

   assign sof = rx_valid && !mid_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_frame  <= 1'b0;
         drop_count <= '0;
      end else begin
         if (rx_valid)      mid_frame  <= !rx_last;
         if (sof && !armed) drop_count <= drop_count + 1'b1;
      end
   end

   assert_drop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: rtl/rxd_lane_writer.sv
module rxd_lane_writer import rxd_pkg::*; #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]     buf_base,
   input  logic [PAR_OFF_W-1:0]  start_off,
   input  logic [PAR_SIZE_W-1:0] idx,
   input  logic [7:0]            din,
   output logic [ADDR_W-1:0]     word_addr,
   output logic [LANES-1:0]      be,
   output logic [WORD_W-1:0]     wdata
);
   logic [ADDR_W-1:0] byte_addr;

   assign byte_addr = buf_base + ADDR_W'(start_off) + ADDR_W'(idx);
   assign word_addr = {byte_addr[ADDR_W-1:LANE_W], LANE_W'(0)};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be[g]          = (byte_addr[LANE_W-1:0] == LANE_W'(g));
      assign wdata[8*g +: 8] = din;
   end
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine import rxd_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int POLL_W     = 8,
   parameter int DROP_W     = 16,
   parameter int POLL_RESET = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              poll_wr,
   input  logic [POLL_W-1:0] poll_din,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [DROP_W-1:0] drop_count
);
   if (ADDR_W != WORD_W) begin : g_bad_addr
      $error("ADDR_W must equal the descriptor word width");
   end
   if (POLL_RESET >= (1 << POLL_W)) begin : g_bad_poll
      $error("POLL_RESET does not fit in POLL_W bits");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("DROP_W must be at least 1");
   end

   eng_state_t            state;
   logic [ADDR_W-1:0]     cur_desc, nxt_desc, buf_ptr;
   logic [PAR_OFF_W-1:0]  buf_off;
   logic [PAR_SIZE_W-1:0] buf_max, byte_cnt;
   logic                  trunc;
   logic [POLL_W-1:0]     poll_reg;
   logic                  sof, accept, store, held, tmr_load, tmr_done;
   logic [ADDR_W-1:0]     lw_addr;
   logic [LANES-1:0]      lw_be;
   logic [WORD_W-1:0]     lw_data, stat_word;

   assign held     = mem_rdata[PAR_HOLD_BIT];
   assign tmr_load = (state == ST_CAP_PAR) && held;
   assign accept   = rx_valid && (((state == ST_ARMED) && sof) || (state == ST_RECV));
   assign store    = accept && (byte_cnt < buf_max);

   rxd_frame_gate #(.DROP_W(DROP_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
      .armed(state == ST_ARMED), .sof(sof), .drop_count(drop_count));

   rxd_poll_timer #(.W(POLL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(poll_reg),
      .expired(tmr_done));

   rxd_lane_writer #(.ADDR_W(ADDR_W)) u_lanes (
      .buf_base(buf_ptr), .start_off(buf_off), .idx(byte_cnt), .din(rx_data),
      .word_addr(lw_addr), .be(lw_be), .wdata(lw_data));

   always_comb begin
      stat_word                   = '0;
      stat_word[STAT_DONE_BIT]    = 1'b1;
      stat_word[STAT_SOF_BIT]     = 1'b1;
      stat_word[STAT_EOF_BIT]     = !trunc;
      stat_word[STAT_CNT_W-1:0]   = byte_cnt[STAT_CNT_W-1:0];
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      unique case (state)
         ST_RD_PAR: begin
            mem_req  = 1'b1;
            mem_addr = cur_desc;
         end
         ST_CAP_PAR: if (!held) begin
            mem_req  = 1'b1;
            mem_addr = cur_desc + ADDR_W'(OFS_NEXT);
         end
         ST_CAP_NXT: begin
            mem_req  = 1'b1;
            mem_addr = cur_desc + ADDR_W'(OFS_BUF);
         end
         ST_ARMED, ST_RECV: if (store) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = lw_addr;
            mem_be    = lw_be;
            mem_wdata = lw_data;
         end
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_desc + ADDR_W'(OFS_STAT);
            mem_be    = '1;
            mem_wdata = stat_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_desc <= '0;
         nxt_desc <= '0;
         buf_ptr  <= '0;
         buf_off  <= '0;
         buf_max  <= '0;
         byte_cnt <= '0;
         trunc    <= 1'b0;
         poll_reg <= POLL_W'(POLL_RESET);
      end else begin
         if (poll_wr) poll_reg <= poll_din;
         if (accept) begin
            if (store) byte_cnt <= byte_cnt + 1'b1;
            else       trunc    <= 1'b1;
         end
         unique case (state)
            ST_IDLE: if (run) begin
               cur_desc <= ring_base;
               state    <= ST_RD_PAR;
            end
            ST_RD_PAR: state <= ST_CAP_PAR;
            ST_CAP_PAR: begin
               buf_off <= mem_rdata[PAR_OFF_LSB +: PAR_OFF_W];
               buf_max <= mem_rdata[PAR_SIZE_W-1:0];
               state   <= held ? ST_HOLD : ST_CAP_NXT;
            end
            ST_CAP_NXT: begin
               nxt_desc <= mem_rdata[ADDR_W-1:0];
               state    <= ST_CAP_BUF;
            end
            ST_CAP_BUF: begin
               buf_ptr  <= mem_rdata[ADDR_W-1:0];
               byte_cnt <= '0;
               trunc    <= 1'b0;
               state    <= ST_ARMED;
            end
            ST_ARMED: begin
               if (accept)    state <= rx_last ? ST_WB : ST_RECV;
               else if (!run) state <= ST_IDLE;
            end
            ST_RECV: if (accept && rx_last) state <= ST_WB;
            ST_WB: begin
               cur_desc <= nxt_desc;
               state    <= run ? ST_RD_PAR : ST_IDLE;
            end
            ST_HOLD: begin
               if (!run)          state <= ST_IDLE;
               else if (tmr_done) state <= ST_RD_PAR;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> !mem_req);
   assert_follow_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WB && run) |=> (mem_req && !mem_we && mem_addr == $past(nxt_desc)));
   assert_status_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_be == '1) |-> $past(rx_valid && rx_last));
   assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !mem_req);
   assert_trunc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RECV && $past(trunc)) |-> trunc);
endmodule

// File: tb/tb_rxd_ring_engine.sv
module tb_rxd_ring_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [31:0] ring_base = '0;
   logic        poll_wr = 1'b0;
   logic [7:0]  poll_din = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_last = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;
   logic [15:0] drop_count;

   always #2 clk = ~clk;

   rxd_ring_engine dut (
      .clk(clk), .rst_n(rst_n), .run(run), .ring_base(ring_base),
      .poll_wr(poll_wr), .poll_din(poll_din), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_last(rx_last), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .drop_count(drop_count));

   // memory model and access log
   logic [7:0]  mem8 [0:1023];
   logic        tb_we = 1'b0;
   logic [9:0]  tb_addr = '0;
   logic [31:0] tb_data = '0;
   logic        log_clr = 1'b0;
   logic [31:0] rd_addr [0:63];
   int          rd_time [0:63];
   int          rd_n = 0, wr_n = 0, cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (log_clr) begin
         rd_n <= 0;
         wr_n <= 0;
      end else if (mem_req) begin
         if (mem_we) wr_n <= wr_n + 1;
         else begin
            if (rd_n < 64) begin
               rd_addr[rd_n] <= mem_addr;
               rd_time[rd_n] <= cyc;
            end
            rd_n <= rd_n + 1;
         end
      end
      if (mem_req && !mem_we)
         mem_rdata <= {mem8[mem_addr[9:0]+3], mem8[mem_addr[9:0]+2],
                       mem8[mem_addr[9:0]+1], mem8[mem_addr[9:0]]};
      if (mem_req && mem_we)
         for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem8[mem_addr[9:0]+k] <= mem_wdata[8*k +: 8];
      if (tb_we)
         for (int k = 0; k < 4; k++) mem8[tb_addr+k] <= tb_data[8*k +: 8];
   end

   int nchk = 0, nerr = 0, exp_drop = 0;
   logic [7:0] fr [0:63];
   int d_off [0:2];
   int d_max [0:2];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic poke(int a, logic [31:0] v);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = 10'(a); tb_data = v;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   function automatic logic [31:0] peekw(int a);
      return {mem8[a+3], mem8[a+2], mem8[a+1], mem8[a]};
   endfunction

   function automatic int dsc(int i); return i * 16; endfunction
   function automatic int bfa(int i); return 256 + i * 64; endfunction

   task automatic set_desc(int i, bit hold, int off, int mx);
      d_off[i] = off; d_max[i] = mx;
      poke(dsc(i), {hold, 2'b00, 3'(off), 4'b0, 22'(mx)});
      poke(dsc(i) + 4, 32'(dsc((i + 1) % 3)));
      poke(dsc(i) + 8, 32'(bfa(i)));
      poke(dsc(i) + 12, 32'h0);
      for (int w = 0; w < 16; w++) poke(bfa(i) + 4 * w, 32'hEEEE_EEEE);
   endtask

   task automatic clr_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_reads(int n);
      for (int g = 0; g < 400 && rd_n < n; g++) @(negedge clk);
   endtask

   task automatic fill_frame(int len);
      for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
   endtask

   task automatic send_frame(int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fr[i]; rx_last = (i == len - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic check_frame(int i, int len);
      int stored, bad;
      logic [31:0] exp;
      stored = (len < d_max[i]) ? len : d_max[i];
      bad = 0;
      for (int j = 0; j < stored; j++)
         if (mem8[bfa(i) + d_off[i] + j] !== fr[j]) bad++;
      chk("R3 buffer bytes at buffer+offset", 32'(bad), 32'h0);
      exp = 32'hC000_0000 | ((len <= d_max[i]) ? 32'h2000_0000 : 32'h0) | 32'(stored);
      chk("R4 R5 R6 status word", peekw(dsc(i) + 12), exp);
      if (d_off[i] + stored < 64)
         chk("R6 R3 byte after stored data untouched",
             32'(mem8[bfa(i) + d_off[i] + stored]), 32'hEE);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int k, len;
      void'($urandom(32'd4021));
      for (int a = 0; a < 1024; a++) mem8[a] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mem_req idle after reset", 32'(mem_req), 32'h0);
      chk("R1 drop_count zero after reset", 32'(drop_count), 32'h0);

      set_desc(0, 1'b1, 0, 40);
      set_desc(1, 1'b0, 3, 40);
      set_desc(2, 1'b0, 2, 6);

      // R8 held descriptor polled with reset interval 7
      clr_log();
      run = 1'b1;
      wait_reads(3);
      chk("R8 held: only param word read", rd_addr[1], 32'h0);
      chk("R8 held: only param word read", rd_addr[2], 32'h0);
      chk("R1 R8 re-poll gap with reset interval", 32'(rd_time[1] - rd_time[0]), 32'd10);
      chk("R8 re-poll gap repeats", 32'(rd_time[2] - rd_time[1]), 32'd10);

      // R10 frame while held is dropped
      clr_log();
      fill_frame(5);
      send_frame(5);
      exp_drop++;
      idle(2);
      chk("R10 drop while held", 32'(drop_count), 32'(exp_drop));
      chk("R8 no writes while held", 32'(wr_n), 32'h0);
      chk("R8 buffer untouched while held", 32'(mem8[bfa(0)]), 32'hEE);

      // R9 new interval
      @(negedge clk); poll_wr = 1'b1; poll_din = 8'd2;
      @(negedge clk); poll_wr = 1'b0;
      clr_log();
      wait_reads(3);
      chk("R9 re-poll gap after interval write", 32'(rd_time[2] - rd_time[1]), 32'd5);

      // R2 release and fetch order
      clr_log();
      poke(dsc(0), {10'b0, 22'd40});
      for (int g = 0; g < 400 && !(rd_n > 0 && rd_addr[rd_n-1] == 32'd8); g++) @(negedge clk);
      chk("R2 fetch next pointer", rd_addr[rd_n-2], 32'h4);
      chk("R2 fetch param first", rd_addr[rd_n-3], 32'h0);
      chk("R2 consecutive fetch cycles", 32'(rd_time[rd_n-1] - rd_time[rd_n-3]), 32'd2);
      idle(4);
      fill_frame(12);
      send_frame(12);
      idle(10);
      check_frame(0, 12);
      set_desc(0, 1'b0, 5, 40);

      // R10 back-to-back frame dropped while engine busy
      fill_frame(9);
      send_frame(9);
      send_frame(4);
      exp_drop++;
      idle(10);
      check_frame(1, 9);
      chk("R10 drop right after frame", 32'(drop_count), 32'(exp_drop));
      chk("R10 next buffer untouched", 32'(mem8[bfa(2) + 2]), 32'hEE);
      set_desc(1, 1'b0, int'($urandom % 8), 4 + int'($urandom % 44));

      // R6 truncation: limit 6, offset 2, frame 10
      fill_frame(10);
      send_frame(10);
      idle(10);
      check_frame(2, 10);
      set_desc(2, 1'b0, int'($urandom % 8), 4 + int'($urandom % 44));

      // R7 wrap to first descriptor
      fill_frame(17);
      send_frame(17);
      idle(10);
      check_frame(0, 17);
      set_desc(0, 1'b0, int'($urandom % 8), 4 + int'($urandom % 44));

      // random frames around the ring (R3 R4 R5 R6 R7)
      k = 1;
      for (int n = 0; n < 12; n++) begin
         len = 1 + int'($urandom % 40);
         fill_frame(len);
         send_frame(len);
         idle(10);
         check_frame(k, len);
         set_desc(k, 1'b0, int'($urandom % 8), 4 + int'($urandom % 44));
         k = (k + 1) % 3;
      end

      // R11 stop and restart at a new base
      @(negedge clk); run = 1'b0;
      idle(2);
      clr_log();
      idle(6);
      chk("R11 no traffic when stopped", 32'(rd_n + wr_n), 32'h0);
      fill_frame(5);
      send_frame(5);
      exp_drop++;
      idle(3);
      chk("R10 R11 drop while stopped", 32'(drop_count), 32'(exp_drop));
      chk("R11 no writes while stopped", 32'(wr_n), 32'h0);
      ring_base = 32'h10;
      clr_log();
      run = 1'b1;
      wait_reads(3);
      chk("R11 restart fetch at ring_base", rd_addr[0], 32'h10);
      idle(4);
      fill_frame(7);
      send_frame(7);
      idle(10);
      check_frame(1, 7);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule